// File: doc/BRIEF.md
# Mode-Switching Cache Index Decoder

This block turns a 48-bit load/store address and an access kind into the signals that steer a 4-way cache with 64-byte lines whose data array holds two bit-copies (an upper and a lower copy) per stored bit. It can run in one of two layouts. In the general layout the two copies in one physical row hold two neighbouring sets, so the full 256-set index is live. In the versioned layout the cache shrinks to half its sets and each row keeps a new version of a line in the upper copy and an old version in the lower copy.

For every valid request the block outputs, one clock later, the tag-array index, the tag to store or compare, the physical row, and the two copy word-line enables. A small state machine holds the layout. A layout change comes from a privileged context and only takes effect in a cycle where the external flush logic reports that the cache has been written back and invalidated. Until then the old layout stays in force and a busy flag is raised. The state machine has four states. ST_GEN and ST_VER are the two settled layouts. ST_PEND_VER and ST_PEND_GEN wait for a flush to finish. The transitions are these:
- A privileged request for the other layout without flush-done moves ST_GEN to ST_PEND_VER, or ST_VER to ST_PEND_GEN.
- The same request arriving together with flush-done moves straight across.
- Flush-done moves each pending state to its target layout.

Top module: `cache_index_mapper`

## Requirements
- R1: After reset the block is in the general layout (ver_mode=0), busy=0, out_valid=0 and every output field, including both word-line enables, is 0.
- R2: out_valid equals in_valid of the previous cycle. When it is 0, out_tag_idx, out_tag, out_row, out_wl_up and out_wl_lo are all 0.
- R3: In both layouts out_tag carries address bits 47:13 (35 bits, including the top index bit) of the address sampled one cycle earlier.
- R4: In the general layout out_tag_idx equals address bits 13:6.
- R5: In the general layout out_row equals address bits 13:7. Address bit 6 = 0 raises only out_wl_up, and bit 6 = 1 raises only out_wl_lo. acc_type has no effect.
- R6: In the versioned layout out_tag_idx is {0, address bits 12:6} and out_row equals address bits 12:6. Address bit 13 has no effect on either.
- R7: In the versioned layout acc_type picks the word lines. 0 (new) raises out_wl_up only, 1 (old) raises out_wl_lo only, 2 (both) raises both, and 3 raises neither.
- R8: A privileged request (mode_req_valid=1, priv=1) for the layout not in force, made without flush_done, sets busy from the next cycle. The layout stays unchanged until the first cycle with flush_done=1. From the edge closing that cycle the new layout is in force and busy is 0. A request that arrives together with flush_done switches at once. An access sampled in the switching cycle uses the old layout.
- R9: A request with priv=0, a request for the layout already in force, and any request made while busy=1 are ignored. ver_mode and busy keep their values.
- R10: flush_done with no pending change has no effect on ver_mode or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| addr | input | 48 | Byte address of the request |
| acc_type | input | 2 | Versioned access kind: 0 new, 1 old, 2 both, 3 none |
| mode_req_valid | input | 1 | Layout change request strobe |
| mode_req_target | input | 1 | Requested layout: 0 general, 1 versioned |
| priv | input | 1 | Request comes from a privileged context |
| flush_done | input | 1 | External write-back and invalidate has completed |
| out_valid | output | 1 | Registered copy of in_valid |
| out_tag_idx | output | 8 | Tag-array set index |
| out_tag | output | 35 | Stored or compared tag |
| out_row | output | 7 | Physical data-array row |
| out_wl_up | output | 1 | Upper-copy word-line enable |
| out_wl_lo | output | 1 | Lower-copy word-line enable |
| ver_mode | output | 1 | Layout in force: 1 versioned |
| busy | output | 1 | Layout change waiting for flush completion |

## Verification
The hardest case to reach from the ports is an access sampled in the very cycle the layout flips. That access must still be decoded with the old layout, while ver_mode changes at the same edge. The stimulus parks the block in a pending state, sends accesses with bit 13 and bit 6 set while it waits, and then raises flush_done together with an access. A later change back is requested together with flush_done, so the immediate path is also taken with a live access. A long pseudo-random phase then mixes rare flush_done pulses, unprivileged requests and requests made while busy. The behavioural model is compared on every cycle throughout.

// File: rtl/cim_pkg.sv
package cim_pkg;

    // Access kind used in the versioned layout
    typedef enum logic [1:0] {
        ACC_NEW  = 2'd0,
        ACC_OLD  = 2'd1,
        ACC_BOTH = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;

    // Layout controller states
    typedef enum logic [1:0] {
        ST_GEN      = 2'd0,
        ST_VER      = 2'd1,
        ST_PEND_VER = 2'd2,
        ST_PEND_GEN = 2'd3
    } mstate_e;

endpackage

// File: rtl/cim_mode_fsm.sv
module cim_mode_fsm
    import cim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_target,
    input  logic priv,
    input  logic flush_done,
    output logic ver_mode,
    output logic busy
);

    mstate_e state_q, state_d;
    logic    cur_layout;
    logic    want_change;

    assign cur_layout  = (state_q == ST_VER) || (state_q == ST_PEND_GEN);
    assign want_change = req_valid && priv && (req_target != cur_layout);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GEN: begin
                if (want_change) begin
                    state_d = flush_done ? ST_VER : ST_PEND_VER;
                end
            end
            ST_VER: begin
                if (want_change) begin
                    state_d = flush_done ? ST_GEN : ST_PEND_GEN;
                end
            end
            ST_PEND_VER: begin
                if (flush_done) begin
                    state_d = ST_VER;
                end
            end
            ST_PEND_GEN: begin
                if (flush_done) begin
                    state_d = ST_GEN;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_GEN;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        ver_mode = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_GEN:      begin ver_mode = 1'b0; busy = 1'b0; end
            ST_VER:      begin ver_mode = 1'b1; busy = 1'b0; end
            ST_PEND_VER: begin ver_mode = 1'b0; busy = 1'b1; end
            ST_PEND_GEN: begin ver_mode = 1'b1; busy = 1'b1; end
        endcase
    end

endmodule

// File: rtl/cim_addr_map.sv
module cim_addr_map
    import cim_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int OFF_W  = 6,
    parameter int IDX_W  = 8,
    parameter int ROW_W  = IDX_W - 1,
    parameter int TAG_W  = ADDR_W - OFF_W - ROW_W
) (
    input  logic              ver_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        acc_type,
    output logic [IDX_W-1:0]  tag_idx,
    output logic [TAG_W-1:0]  tag,
    output logic [ROW_W-1:0]  row,
    output logic              wl_up,
    output logic              wl_lo
);

    logic [IDX_W-1:0] set_idx;
    acc_e             kind;

    assign set_idx = addr[OFF_W +: IDX_W];
    assign tag     = addr[ADDR_W-1 -: TAG_W];
    assign kind    = acc_e'(acc_type);

    always_comb begin
        if (!ver_mode) begin
            // neighbouring sets share a row; low index bit picks the copy
            tag_idx = set_idx;
            row     = set_idx[IDX_W-1:1];
            wl_up   = ~set_idx[0];
            wl_lo   = set_idx[0];
        end else begin
            // half the sets; top index bit dropped
            tag_idx = {1'b0, set_idx[IDX_W-2:0]};
            row     = set_idx[ROW_W-1:0];
            unique case (kind)
                ACC_NEW:  begin wl_up = 1'b1; wl_lo = 1'b0; end
                ACC_OLD:  begin wl_up = 1'b0; wl_lo = 1'b1; end
                ACC_BOTH: begin wl_up = 1'b1; wl_lo = 1'b1; end
                ACC_NONE: begin wl_up = 1'b0; wl_lo = 1'b0; end
            endcase
        end
    end

endmodule

// File: rtl/cim_out_stage.sv
module cim_out_stage #(
    parameter int IDX_W = 8,
    parameter int ROW_W = 7,
    parameter int TAG_W = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] tag_idx_d,
    input  logic [TAG_W-1:0] tag_d,
    input  logic [ROW_W-1:0] row_d,
    input  logic             wl_up_d,
    input  logic             wl_lo_d,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_tag_idx,
    output logic [TAG_W-1:0] out_tag,
    output logic [ROW_W-1:0] out_row,
    output logic             out_wl_up,
    output logic             out_wl_lo
);

    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid   <= 1'b0;
            out_tag_idx <= '0;
            out_tag     <= '0;
            out_row     <= '0;
            out_wl_up   <= 1'b0;
            out_wl_lo   <= 1'b0;
        end else begin
            out_valid   <= 1'b1;
            out_tag_idx <= tag_idx_d;
            out_tag     <= tag_d;
            out_row     <= row_d;
            out_wl_up   <= wl_up_d;
            out_wl_lo   <= wl_lo_d;
        end
    end

endmodule

// File: rtl/cache_index_mapper.sv
module cache_index_mapper #(
    parameter int ADDR_W     = 48,
    parameter int LINE_BYTES = 64,
    parameter int NUM_SETS   = 256
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            in_valid,
    input  logic [ADDR_W-1:0]                               addr,
    input  logic [1:0]                                      acc_type,
    input  logic                                            mode_req_valid,
    input  logic                                            mode_req_target,
    input  logic                                            priv,
    input  logic                                            flush_done,
    output logic                                            out_valid,
    output logic [$clog2(NUM_SETS)-1:0]                     out_tag_idx,
    output logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(NUM_SETS):0] out_tag,
    output logic [$clog2(NUM_SETS)-2:0]                     out_row,
    output logic                                            out_wl_up,
    output logic                                            out_wl_lo,
    output logic                                            ver_mode,
    output logic                                            busy
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(NUM_SETS);
    localparam int ROW_W = IDX_W - 1;
    localparam int TAG_W = ADDR_W - OFF_W - ROW_W;

    logic [IDX_W-1:0] map_idx;
    logic [TAG_W-1:0] map_tag;
    logic [ROW_W-1:0] map_row;
    logic             map_up;
    logic             map_lo;

    cim_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (mode_req_valid),
        .req_target (mode_req_target),
        .priv       (priv),
        .flush_done (flush_done),
        .ver_mode   (ver_mode),
        .busy       (busy)
    );

    cim_addr_map #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .ROW_W  (ROW_W),
        .TAG_W  (TAG_W)
    ) u_map (
        .ver_mode (ver_mode),
        .addr     (addr),
        .acc_type (acc_type),
        .tag_idx  (map_idx),
        .tag      (map_tag),
        .row      (map_row),
        .wl_up    (map_up),
        .wl_lo    (map_lo)
    );

    cim_out_stage #(
        .IDX_W (IDX_W),
        .ROW_W (ROW_W),
        .TAG_W (TAG_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .tag_idx_d   (map_idx),
        .tag_d       (map_tag),
        .row_d       (map_row),
        .wl_up_d     (map_up),
        .wl_lo_d     (map_lo),
        .out_valid   (out_valid),
        .out_tag_idx (out_tag_idx),
        .out_tag     (out_tag),
        .out_row     (out_row),
        .out_wl_up   (out_wl_up),
        .out_wl_lo   (out_wl_lo)
    );

endmodule

// File: rtl/cim_checker.sv
module cim_checker #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 8,
    parameter int ROW_W  = 7,
    parameter int TAG_W  = 35
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] addr,
    input logic              priv,
    input logic              flush_done,
    input logic              out_valid,
    input logic [IDX_W-1:0]  out_tag_idx,
    input logic [TAG_W-1:0]  out_tag,
    input logic [ROW_W-1:0]  out_row,
    input logic              out_wl_up,
    input logic              out_wl_lo,
    input logic              ver_mode,
    input logic              busy
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wl_up && !out_wl_lo)); // R2
    AST_TAG_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_tag == $past(addr[ADDR_W-1 -: TAG_W]))); // R3
    AST_GEN_ONE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ver_mode) |=> (out_wl_up ^ out_wl_lo)); // R5
    AST_VER_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ver_mode) |=> !out_tag_idx[IDX_W-1]); // R6
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_done |=> $stable(ver_mode)); // R8
    AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && flush_done) |=> (!busy && (ver_mode != $past(ver_mode)))); // R8
    AST_NONPRIV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !priv) |=> (!busy && $stable(ver_mode))); // R9

endmodule

bind cache_index_mapper cim_checker #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .ROW_W  (ROW_W),
    .TAG_W  (TAG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .addr        (addr),
    .priv        (priv),
    .flush_done  (flush_done),
    .out_valid   (out_valid),
    .out_tag_idx (out_tag_idx),
    .out_tag     (out_tag),
    .out_row     (out_row),
    .out_wl_up   (out_wl_up),
    .out_wl_lo   (out_wl_lo),
    .ver_mode    (ver_mode),
    .busy        (busy)
);

// File: tb/cache_index_mapper_bench.sv
`timescale 1ns/1ps
module cache_index_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [47:0] addr = '0;
    logic [1:0]  acc_type = '0;
    logic        mode_req_valid = 1'b0;
    logic        mode_req_target = 1'b0;
    logic        priv = 1'b0;
    logic        flush_done = 1'b0;
    logic        out_valid;
    logic [7:0]  out_tag_idx;
    logic [34:0] out_tag;
    logic [6:0]  out_row;
    logic        out_wl_up, out_wl_lo, ver_mode, busy;

    int errors = 0;
    int checks = 0;
    string mtag = "R1";

    always #5 clk = ~clk;

    cache_index_mapper u_cache_index_mapper (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr(addr),
        .acc_type(acc_type), .mode_req_valid(mode_req_valid),
        .mode_req_target(mode_req_target), .priv(priv),
        .flush_done(flush_done), .out_valid(out_valid),
        .out_tag_idx(out_tag_idx), .out_tag(out_tag), .out_row(out_row),
        .out_wl_up(out_wl_up), .out_wl_lo(out_wl_lo),
        .ver_mode(ver_mode), .busy(busy)
    );

    // behavioural reference
    logic        e_valid, e_up, e_lo, m_mode, m_busy, m_tgt, e_used;
    logic [7:0]  e_idx;
    logic [34:0] e_tag;
    logic [6:0]  e_row;
    bit          seen = 0;

    always @(posedge clk) begin
        int s;
        if (!rst_n) begin
            e_valid = 0; e_idx = 0; e_tag = 0; e_row = 0; e_up = 0; e_lo = 0;
            m_mode = 0; m_busy = 0; m_tgt = 0; e_used = 0;
        end else begin
            e_valid = in_valid;
            e_used  = m_mode;
            if (in_valid) begin
                s = int'(addr[13:6]);
                e_tag = addr[47:13];
                if (!m_mode) begin
                    e_idx = 8'(s); e_row = 7'(s / 2);
                    e_up = (s % 2 == 0); e_lo = (s % 2 == 1);
                end else begin
                    e_idx = 8'(s % 128); e_row = 7'(s % 128);
                    e_up = (acc_type == 0 || acc_type == 2);
                    e_lo = (acc_type == 1 || acc_type == 2);
                end
            end else begin
                e_idx = 0; e_tag = 0; e_row = 0; e_up = 0; e_lo = 0;
            end
            if (m_busy) begin
                if (flush_done) begin m_mode = m_tgt; m_busy = 0; end
            end else if (mode_req_valid && priv && mode_req_target != m_mode) begin
                if (flush_done) m_mode = mode_req_target;
                else begin m_busy = 1; m_tgt = mode_req_target; end
            end
        end
        seen = 1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (seen) begin
            chk(rst_n ? "R2 valid" : "R1 valid", 64'(out_valid), 64'(e_valid));
            chk("R3 tag", 64'(out_tag), 64'(e_tag));
            chk(e_used ? "R6 index" : "R4 index", 64'(out_tag_idx), 64'(e_idx));
            chk(e_used ? "R6 row" : "R5 row", 64'(out_row), 64'(e_row));
            chk(e_used ? "R7 upper" : "R5 upper", 64'(out_wl_up), 64'(e_up));
            chk(e_used ? "R7 lower" : "R5 lower", 64'(out_wl_lo), 64'(e_lo));
            chk({mtag, " mode"}, 64'(ver_mode), 64'(m_mode));
            chk({mtag, " busy"}, 64'(busy), 64'(m_busy));
        end
    end

    task automatic drive(input logic v, input logic [47:0] a, input logic [1:0] t,
                         input logic rv, input logic rt, input logic p, input logic fd);
        @(negedge clk);
        in_valid = v; addr = a; acc_type = t;
        mode_req_valid = rv; mode_req_target = rt; priv = p; flush_done = fd;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) drive(1, 48'hFFFF_FFFF_FFFF, 2, 1, 1, 1, 1); // R1 inputs busy in reset
        drive(0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        mtag = "R8";
        // general layout, access type varied (R5 ignore)
        drive(1, 48'h0000_0000_0000, 0, 0, 0, 0, 0);
        drive(1, 48'h0000_0000_0040, 2, 0, 0, 0, 0);
        drive(1, 48'hFFFF_FFFF_FFFF, 3, 0, 0, 0, 0);
        drive(1, 48'hABCD_1234_3FBF, 1, 0, 0, 0, 0);
        drive(0, 48'h1234_5678_9ABC, 2, 0, 0, 0, 0);
        // R9: unprivileged and same-layout requests
        mtag = "R9";
        drive(1, 48'h0000_0000_2000, 0, 1, 1, 0, 0);
        drive(1, 48'h0000_0000_2040, 0, 1, 0, 1, 0);
        drive(0, 0, 0, 1, 1, 0, 1);
        // R10: stray flush completion
        mtag = "R10";
        drive(0, 0, 0, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 1, 1, 1);
        // R8: request without flush, accesses while pending
        mtag = "R8";
        drive(1, 48'h0000_0000_3FC0, 1, 1, 1, 1, 0);
        drive(1, 48'h0000_0000_2040, 0, 0, 0, 0, 0);
        drive(1, 48'h7777_0000_3F80, 2, 1, 0, 1, 0); // R9 request while busy
        drive(1, 48'h0000_0000_20C0, 3, 0, 0, 0, 0);
        // switching cycle carries an access (decoded with the old layout)
        drive(1, 48'h0000_0000_2040, 0, 0, 0, 0, 1);
        // R6/R7 versioned layout, all access kinds, bit 13 set and clear
        drive(1, 48'h0000_0000_2040, 0, 0, 0, 0, 0);
        drive(1, 48'h0000_0000_3FC0, 1, 0, 0, 0, 0);
        drive(1, 48'h0000_0000_1FC0, 2, 0, 0, 0, 0);
        drive(1, 48'hFFFF_FFFF_FFFF, 3, 0, 0, 0, 0);
        drive(0, 48'hFFFF_FFFF_FFFF, 2, 0, 0, 0, 0);
        // immediate change back together with flush completion
        drive(1, 48'h0000_0000_2040, 2, 1, 0, 1, 1);
        drive(1, 48'h0000_0000_2040, 2, 0, 0, 0, 0);
        // mixed pseudo-random phase
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[0], {16'($urandom), 32'($urandom)}, r[2:1], r[3] & r[4],
                  r[5], r[6] | r[7], (r[11:8] == 4'd0));
        end
        drive(0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule